// File: doc/BRIEF.md
# Counted Serial Result Shifter

This block is the read port of a sampling converter. A host frames each read with a port-enable strobe and supplies its own serial clock. The block returns one 8-bit conversion result, most significant bit first, on a single data line. A separate output-enable flag stands in for the line's high-impedance state. Exactly as many bits as the result is wide go out per enable edge. After the last bit the line is released and further clock edges do nothing until the next enable edge re-arms the port.

The conversion sequencer hands the block a parallel result together with a one-cycle load strobe. The block keeps that value in a holding register, independently of any read in progress. The shift register takes a copy of the holding register only at the enable rising edge. A read started before a conversion completes therefore returns the earlier result. A result that lands in the middle of a read cannot disturb the bits on the wire.

Both host pins are asynchronous to the system clock. Each passes through a multi-stage synchronizer and an edge detector, and all state runs in the system clock domain. The host clock must therefore hold each phase for a few system clock cycles. The block works the same with a free-running or a gated serial clock.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `sdata_oe` and `sdata_out` are 0. Serial clock edges produce no output until a rising edge of `port_en` has been seen.
- R2: A rising edge of `port_en` resets the bit count to zero, deasserts `sdata_oe`, and copies the held result into the shift register.
- R3: Each rising edge of `sclk` after arming drives the next result bit onto `sdata_out`, starting at bit 7 and ending at bit 0. `sdata_oe` goes high with the first bit.
- R4: On the falling `sclk` edge that follows the eighth bit, `sdata_oe` returns to 0.
- R5: `sclk` edges after the eighth bit leave `sdata_oe` at 0 until the next `port_en` rising edge.
- R6: A `result_load` during a read does not change the bits of that read. The next read returns the newly loaded value.
- R7: Without a new `result_load`, every read returns the last loaded value again.
- R8: Reads are correct for any `sclk` phase length of at least SYNC_STAGES+2 system clocks, regular or irregular.
- R9: A pin edge changes the outputs on the third system clock edge after the pin changes, with the default of two synchronizer stages.
- R10: While `sdata_oe` is 0, `sdata_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, asynchronous |
| port_en | input | 1 | Port enable; its rising edge re-arms the port |
| result_in | input | DATA_W | Parallel conversion result |
| result_load | input | 1 | One-cycle strobe that stores result_in |
| sdata_out | output | 1 | Serial data bit |
| sdata_oe | output | 1 | High while the data line is driven; low models high impedance |

## Verification
The bench reads all 256 result values, varying the serial clock phase length from read to read. A wrong bit order or an off-by-one shift would show up as a corrupted byte.

It also sends extra clock edges after the eighth bit. A port that re-armed itself would drive the line again. It also sends clock edges before any enable edge; a port that was not properly idle after reset would drive the line.

A result is loaded in the middle of a read. A design that fed the shifter straight from the result register would return mixed bits.

The synchronizer latency is measured cycle by cycle. An extra or a missing register stage would move the moment the output enable rises.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  output srp_pkg::edge_t edges
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  always_comb begin
    edges.rise = chain_q[STAGES-1] & ~prev_q;
    edges.fall = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/srp_result_hold.sv
module srp_result_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] held
);
  logic [DATA_W-1:0] held_d;

  always_comb begin
    held_d = load ? din : held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held_d;
  end
endmodule

// File: rtl/srp_shift_engine.sv
module srp_shift_engine #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  srp_pkg::edge_t    en_edge,
  input  srp_pkg::edge_t    sck_edge,
  input  logic [DATA_W-1:0] held,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              dout,
  output logic              oe
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              armed_q, armed_d;
  logic              dout_d, oe_d;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = bit_cnt;
    armed_d = armed_q;
    dout_d  = dout;
    oe_d    = oe;
    if (en_edge.rise) begin
      shreg_d = held;
      cnt_d   = '0;
      armed_d = 1'b1;
      dout_d  = 1'b0;
      oe_d    = 1'b0;
    end else if (armed_q && sck_edge.rise && bit_cnt != LAST) begin
      dout_d  = shreg_q[DATA_W-1];
      shreg_d = {shreg_q[DATA_W-2:0], 1'b0};
      cnt_d   = bit_cnt + 1'b1;
      oe_d    = 1'b1;
    end else if (armed_q && sck_edge.fall && bit_cnt == LAST) begin
      armed_d = 1'b0;
      dout_d  = 1'b0;
      oe_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bit_cnt <= '0;
      armed_q <= 1'b0;
      dout    <= 1'b0;
      oe      <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      bit_cnt <= cnt_d;
      armed_q <= armed_d;
      dout    <= dout_d;
      oe      <= oe_d;
    end
  end
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              port_en,
  input  logic [DATA_W-1:0] result_in,
  input  logic              result_load,
  output logic              sdata_out,
  output logic              sdata_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  srp_pkg::edge_t    en_edge, sck_edge;
  logic [DATA_W-1:0] held;
  logic [CNT_W-1:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  srp_edge_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin(port_en), .edges(en_edge));

  srp_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin(sclk), .edges(sck_edge));

  srp_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load(result_load),
    .din(result_in), .held(held));

  srp_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .en_edge(en_edge), .sck_edge(sck_edge),
    .held(held), .bit_cnt(bit_cnt), .dout(sdata_out), .oe(sdata_oe));
endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_rise,
  input logic             sck_rise,
  input logic             sck_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdata_oe,
  input logic             sdata_out
);
  // R2
  arm_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (bit_cnt == '0 && !sdata_oe));
  // R3
  oe_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(sck_rise));
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && sck_fall && !en_rise && bit_cnt == CNT_W'(DATA_W)) |=> !sdata_oe);
  // R5
  ignore_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdata_oe && sck_rise && !en_rise && bit_cnt == CNT_W'(DATA_W)) |=> !sdata_oe);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W));
  // R10
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_out);
endmodule

bind serial_result_port serial_result_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en_rise(en_edge.rise), .sck_rise(sck_edge.rise),
  .sck_fall(sck_edge.fall), .bit_cnt(bit_cnt), .sdata_oe(sdata_oe), .sdata_out(sdata_out));

// File: tb/serial_result_port_test.sv
module serial_result_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic port_en = 1'b0;
  logic [7:0] result_in = '0;
  logic result_load = 1'b0;
  logic sdata_out, sdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  serial_result_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .port_en(port_en),
    .result_in(result_in), .result_load(result_load),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    result_in = v;
    result_load = 1'b1;
    @(negedge clk);
    result_load = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    port_en = 1'b1;
    wait_cyc(6);
    port_en = 1'b0;
    wait_cyc(6);
  endtask

  // reads one byte; mid_load >= 0 loads mid_val after that many bits
  task automatic read_byte(input int gap, input int mid_at, input logic [7:0] mid_val,
                           output logic [7:0] b, output bit oe_ok);
    b = '0;
    oe_ok = 1;
    for (int i = 0; i < 8; i++) begin
      if (i == mid_at) load(mid_val);
      @(negedge clk);
      sclk = 1'b1;
      wait_cyc(gap + (i % 3));
      if (!sdata_oe) oe_ok = 0;
      b = {b[6:0], sdata_out};
      sclk = 1'b0;
      wait_cyc(gap);
    end
  endtask

  initial begin
    logic [7:0] got;
    bit oe_ok;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1
    check(sdata_oe == 0 && sdata_out == 0, "R1 reset", {sdata_oe, sdata_out}, 0);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; wait_cyc(5);
      check(sdata_oe == 0, "R1 no output before arm", sdata_oe, 0);
      sclk = 1'b0; wait_cyc(5);
    end

    // R9 latency of first bit
    load(8'hA5);
    arm();
    @(negedge clk);
    sclk = 1'b1;
    wait_cyc(2);
    check(sdata_oe == 0, "R9 not before third edge", sdata_oe, 0);
    wait_cyc(1);
    check(sdata_oe == 1 && sdata_out == 1, "R9 first bit on third edge", {sdata_oe, sdata_out}, 3);
    sclk = 1'b0;
    wait_cyc(5);
    // R2 re-arm mid-read drops enable
    arm();
    check(sdata_oe == 0, "R2 arm clears enable", sdata_oe, 0);

    // R3 R8 exhaustive sweep with varying phase length
    for (int v = 0; v < 256; v++) begin
      load(v[7:0]);
      arm();
      read_byte(4 + (v % 5), -1, 8'h00, got, oe_ok);
      check(got == v[7:0] && oe_ok, "R3 R8 byte sweep", got, v);
      // R4
      wait_cyc(1);
      check(sdata_oe == 0, "R4 release after eighth fall", sdata_oe, 0);
      if (v % 32 == 0) begin
        // R5 extra clocks ignored
        for (int k = 0; k < 3; k++) begin
          sclk = 1'b1; wait_cyc(5);
          check(sdata_oe == 0 && sdata_out == 0, "R5 extra clock ignored", sdata_oe, 0);
          sclk = 1'b0; wait_cyc(5);
        end
      end
    end

    // R6 mid-read load
    load(8'h3C);
    arm();
    read_byte(5, 3, 8'hC3, got, oe_ok);
    check(got == 8'h3C && oe_ok, "R6 mid-read load no corruption", got, 8'h3C);
    arm();
    read_byte(5, -1, 8'h00, got, oe_ok);
    check(got == 8'hC3, "R6 next read returns new value", got, 8'hC3);
    // R7 repeat read without load
    arm();
    read_byte(6, -1, 8'h00, got, oe_ok);
    check(got == 8'hC3, "R7 repeated read", got, 8'hC3);
    // R10
    wait_cyc(2);
    check(sdata_out == 0, "R10 idle line low", sdata_out, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule